// File: doc/BRIEF.md
# Serial ADC Output Shifter

This block is the device end of a three-wire serial link on a 12-bit successive-approximation converter. It has a chip-select/shutdown input, a data clock and a data output that can float. While chip-select is high the block is in power-down and the output floats. After chip-select falls, the block counts falling edges of the data clock. The first two edges form an acquisition window. At the end of that window the parallel conversion result and the tail-mode input are captured. The third edge starts driving a low null bit, and the next twelve edges present the result most significant bit first.

Clocks that arrive after the last result bit, with chip-select still low, are handled by the captured tail mode. In replay mode the word is sent again least significant bit first, with the final bit shared at the turnaround, and zeros follow. In zero mode only zeros follow. The edge counter saturates, so any number of extra clocks keeps the output at zero. The data clock and chip-select are sampled in the system clock domain. The output is given as a value plus an enable, which an external pad turns into a tri-state pin.

Top module: `adc_serial_shifter`

## Requirements
- R1: While `cs_n` is high, or `rst` is asserted, `dout_oe` is 0 and `dout` is 0. Raising `cs_n` mid-transfer takes effect in the same cycle.
- R2: After `cs_n` falls, `dout_oe` stays 0 through the first and second falling edges of `dclk`. The falling edge of `cs_n` alone never enables the output.
- R3: The third falling edge of `dclk` sets `dout_oe` to 1 and `dout` to 0 (the null bit).
- R4: Falling edges 4 through 15 present result bits 11 down to 0, one bit per edge.
- R5: With the captured `mode` = 1 (replay), falling edges 16 through 26 present result bits 1 up to 11, and every later edge presents 0.
- R6: With the captured `mode` = 0 (zeros), every falling edge from the 16th onward presents 0.
- R7: Any number of extra edges after the tail keeps `dout_oe` at 1 and `dout` at 0, with no wrap-around.
- R8: `result` and `mode` are captured on the second falling edge. Changes to them after that edge do not alter the transfer in progress.
- R9: A new low pulse on `cs_n` after an aborted transfer restarts from acquisition, with the edge count at zero.
- R10: The outputs change only in the cycle after a sampled falling edge of `dclk`, or when `cs_n` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples `dclk` and `cs_n` |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select / shutdown, active low |
| dclk | input | 1 | Serial data clock; each level held at least one `clk` cycle |
| mode | input | 1 | Tail mode: 1 replays the word LSB first, 0 sends zeros |
| result | input | 12 | Parallel conversion result |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the data pin; 0 means floating |

## Verification
The assertions assume that `dclk` is synchronous to `clk` and that each of its levels lasts at least one `clk` cycle, so that the block sees every falling edge exactly once. They also assume that `cs_n` never changes in the same cycle as a `dclk` fall. The bench drives all inputs on the falling edge of `clk`. It holds each `dclk` level for two cycles and moves `cs_n` only while `dclk` is high and stable. Random words and modes are mixed with alternating, all-ones and all-zeros words. Some transfers also scramble `result` and `mode` after capture, or abort partway through.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    localparam int RES_W_DEF     = 12;
    localparam int ACQ_EDGES_DEF = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_NULL,
        PH_MSB,
        PH_REPLAY,
        PH_ZERO
    } phase_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_t;

    // Edge count at which the tail zeros begin and the counter stops.
    function automatic int sat_count(input int acq, input int w);
        return acq + 2 * w + 1;
    endfunction

endpackage

// File: rtl/ser_fall_det.sv
module ser_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic dclk,
    output logic fall
);
    logic dclk_q;

    always_ff @(posedge clk) begin
        if (rst) dclk_q <= 1'b1;
        else     dclk_q <= dclk;
    end

    assign fall = dclk_q & ~dclk;
endmodule

// File: rtl/ser_edge_counter.sv
module ser_edge_counter #(
    parameter int ACQ = 2,
    parameter int SAT = 27,
    parameter int CW  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          fall,
    output logic [CW-1:0] cnt,
    output logic          capture
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);
    localparam logic [CW-1:0] CAP_V = CW'(ACQ - 1);

    always_ff @(posedge clk) begin
        if (rst || cs_n)                 cnt <= '0;
        else if (fall && (cnt != SAT_V)) cnt <= cnt + 1'b1;
    end

    assign capture = !cs_n && fall && (cnt == CAP_V);
endmodule

// File: rtl/ser_word_hold.sv
module ser_word_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         mode_in,
    input  logic [W-1:0] word_in,
    output logic         retx,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            retx <= 1'b0;
        end else if (load) begin
            word <= word_in;
            retx <= mode_in;
        end
    end
endmodule

// File: rtl/ser_bit_select.sv
module ser_bit_select
    import adc_ser_pkg::*;
#(
    parameter int W   = 12,
    parameter int ACQ = 2,
    parameter int CW  = 5
) (
    input  logic          cs_n,
    input  logic [CW-1:0] cnt,
    input  logic          retx,
    input  logic [W-1:0]  word,
    output pin_t          pin
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] NULL_V  = CW'(ACQ + 1);
    localparam logic [CW-1:0] MSB0_V  = CW'(ACQ + 2);
    localparam logic [CW-1:0] MSBN_V  = CW'(ACQ + 1 + W);
    localparam logic [CW-1:0] REP0_V  = CW'(ACQ + 2 + W);
    localparam logic [CW-1:0] REPN_V  = CW'(ACQ + 2 * W);

    phase_t          phase;
    logic [CW-1:0]   off_msb;
    logic [CW-1:0]   off_rep;
    logic [IW-1:0]   idx_msb;
    logic [IW-1:0]   idx_rep;

    always_comb begin
        if (cs_n || cnt < NULL_V) phase = PH_IDLE;
        else if (cnt == NULL_V)   phase = PH_NULL;
        else if (cnt <= MSBN_V)   phase = PH_MSB;
        else if (cnt <= REPN_V)   phase = PH_REPLAY;
        else                      phase = PH_ZERO;
    end

    assign off_msb = cnt - MSB0_V;
    assign off_rep = cnt - REP0_V;
    assign idx_msb = IW'(W - 1) - IW'(off_msb);
    assign idx_rep = IW'(off_rep) + IW'(1);

    always_comb begin
        pin = '{oe: 1'b1, val: 1'b0};
        unique case (phase)
            PH_IDLE:   pin = '{oe: 1'b0, val: 1'b0};
            PH_NULL:   pin.val = 1'b0;
            PH_MSB:    pin.val = word[idx_msb];
            PH_REPLAY: pin.val = retx & word[idx_rep];
            PH_ZERO:   pin.val = 1'b0;
            default:   pin = '{oe: 1'b0, val: 1'b0};
        endcase
    end
endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter
    import adc_ser_pkg::*;
#(
    parameter int RES_W     = RES_W_DEF,
    parameter int ACQ_EDGES = ACQ_EDGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             dclk,
    input  logic             mode,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe
);
    localparam int SAT = sat_count(ACQ_EDGES, RES_W);
    localparam int CW  = $clog2(SAT + 1);

    logic             fall;
    logic [CW-1:0]    cnt;
    logic             capture;
    logic             retx;
    logic [RES_W-1:0] word;
    pin_t             pin;

    ser_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .dclk (dclk),
        .fall (fall)
    );

    ser_edge_counter #(.ACQ(ACQ_EDGES), .SAT(SAT), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .fall    (fall),
        .cnt     (cnt),
        .capture (capture)
    );

    ser_word_hold #(.W(RES_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (capture),
        .mode_in (mode),
        .word_in (result),
        .retx    (retx),
        .word    (word)
    );

    ser_bit_select #(.W(RES_W), .ACQ(ACQ_EDGES), .CW(CW)) u_sel (
        .cs_n (cs_n | rst),
        .cnt  (cnt),
        .retx (retx),
        .word (word),
        .pin  (pin)
    );

    assign dout    = pin.val;
    assign dout_oe = pin.oe;
endmodule

// File: rtl/adc_serial_shifter_chk.sv
module adc_serial_shifter_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic dclk,
    input logic dout,
    input logic dout_oe
);
    logic dclk_d;

    always_ff @(posedge clk) begin
        if (rst) dclk_d <= 1'b1;
        else     dclk_d <= dclk;
    end

    // R1
    float_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!dout_oe && !dout));

    // R2
    no_enable_on_select_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !dout_oe);

    // R3
    null_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> !dout);

    // R7
    enable_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && !cs_n) |=> (cs_n || dout_oe));

    // R10
    change_on_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !(dclk_d && !dclk)) |=> (cs_n || ($stable(dout) && $stable(dout_oe))));
endmodule

bind adc_serial_shifter adc_serial_shifter_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .dclk    (dclk),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/sim_adc_serial_shifter.sv
module sim_adc_serial_shifter;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         dclk = 1'b1;
    logic         mode = 1'b0;
    logic [W-1:0] result = '0;
    logic         dout;
    logic         dout_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_serial_shifter u0 (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .dclk    (dclk),
        .mode    (mode),
        .result  (result),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    task automatic check(input string req, input logic [1:0] exp);
        n_chk++;
        if ({dout_oe, dout} !== exp) begin
            n_fail++;
            $display("FAIL %s: {oe,dout} actual %b expected %b", req, {dout_oe, dout}, exp);
        end
    endtask

    // Expected {oe,bit} after falling edge number n of a transfer.
    function automatic logic [1:0] expect_pin(input int n, input bit retx, input logic [W-1:0] w);
        if (n <= 2)          return 2'b00;
        if (n == 3)          return 2'b10;
        if (n <= 3 + W)      return {1'b1, w[W - 1 - (n - 4)]};
        if (n <= 2 + 2 * W)  return {1'b1, retx ? w[n - 3 - W] : 1'b0};
        return 2'b10;
    endfunction

    function automatic string tag_of(input int n, input bit retx);
        if (n <= 2)         return "R2";
        if (n == 3)         return "R3";
        if (n <= 3 + W)     return "R4";
        if (n <= 2 + 2 * W) return retx ? "R5" : "R6";
        return "R7";
    endfunction

    task automatic transfer(input logic [W-1:0] w, input bit retx, input int edges,
                            input bit scramble, input bit fresh);
        @(negedge clk);
        cs_n   = 1'b0;
        mode   = retx;
        result = w;
        @(negedge clk);
        check(fresh ? "R9" : "R2", 2'b00);
        for (int n = 1; n <= edges; n++) begin
            dclk = 1'b0;
            @(negedge clk);
            check((fresh && n <= 3) ? "R9" : tag_of(n, retx), expect_pin(n, retx, w));
            if (scramble && n == 2) begin
                result = W'($urandom);
                mode   = ~retx;
            end
            dclk = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check("R10", expect_pin(n, retx, w));
            if (scramble && n == 3 + W) check("R8", expect_pin(n, retx, w));
        end
        cs_n = 1'b1;
        #1;
        check("R1", 2'b00);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 2'b00);

        transfer(12'hAAA, 1'b1, 30, 1'b0, 1'b0);
        transfer(12'h555, 1'b0, 30, 1'b0, 1'b0);
        transfer(12'hFFF, 1'b1, 30, 1'b0, 1'b0);
        transfer(12'hFFF, 1'b0, 30, 1'b0, 1'b0);
        transfer(12'h000, 1'b1, 30, 1'b0, 1'b0);
        transfer(12'h801, 1'b1, 60, 1'b0, 1'b0);
        transfer(12'h5A3, 1'b1, 30, 1'b1, 1'b0);
        transfer(12'hC3C, 1'b0, 30, 1'b1, 1'b0);
        transfer(12'h9E1, 1'b1, 8, 1'b0, 1'b0);
        transfer(12'h1B7, 1'b1, 30, 1'b0, 1'b1);
        for (int k = 0; k < 24; k++) begin
            transfer(W'($urandom), 1'($urandom), 16 + int'($urandom % 20),
                     1'($urandom), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule